// File: doc/BRIEF.md
# I/O Rack Address Allocator

This block builds the I/O point address map for a controller made of one processor rack followed by a chain of expansion racks. Every rack has eight slots, A to H. Each slot reports its point capacity through a 2-bit switch code. After a start strobe, the block walks the racks in order and the slots A to H inside each rack, at one slot per clock. For each slot it emits the first address, the last address and the capacity in points. Addresses accumulate across the whole system, so each rack begins exactly where the previous one stopped.

Every expansion rack also carries an 8-bit starting-address switch. The switch value counts in units of eight points. During the walk the block compares that switch against the chained start it has computed, and it sets one error bit per expansion rack on a mismatch. It raises a separate limit error when the chained start of the final rack lies above the allowed maximum. A busy level covers the walk. A done level rises with the last slot result and stays high until the next start.

Top module: `rack_addr_alloc`

## Requirements
- R1: Each slot code has bit 1 for the first switch and bit 0 for the second switch, where 1 means open. Code 00 gives 0 points, 10 gives 8, 01 gives 16 and 11 gives 32, and this value appears on `slotPoints`.
- R2: The first start pulse accepted while idle is sampled at clock edge E0. At edge E(j+1) the block registers slot j with `slotValid` high. Slots run in rack-major order, slot A to H (index 0 to 7), with rack 0 as the processor rack. Slot j lives in capacity bits `capCodes[2*j +: 2]`.
- R3: Slot A of rack 0 starts at address 0. Every later slot starts at the previous slot's start plus the previous slot's points, and this holds across rack boundaries.
- R4: An occupied slot ends at start + points − 1. An empty slot reports 0 points and start = end = the next free address, so it consumes no addresses.
- R5: Expansion rack i (i ≥ 1) reads its switch from `rackSw[8*(i-1) +: 8]`, and the switch's start address is that value × 8. Bit i−1 of `rackErr` is 1 exactly when this address differs from the chained start of rack i.
- R6: `limitErr` is 1 exactly when the chained start of the last rack is greater than LAST_START_MAX (184).
- R7: `busy` is high from E0 until the last slot is emitted. `done` rises at the edge that registers the last slot and holds until the next accepted start. That start clears `done`, `rackErr` and `limitErr`.
- R8: A start pulse while `busy` is ignored: the walk continues unchanged.
- R9: After reset `busy`, `done`, `slotValid`, `rackErr` and `limitErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a walk when idle |
| capCodes | input | NUM_RACKS*16 (64) | 2-bit capacity code per slot, flat index rack*8+slot |
| rackSw | input | (NUM_RACKS-1)*SW_W (24) | Starting-address switch of each expansion rack |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last walk finished |
| slotValid | output | 1 | Slot result valid this cycle |
| slotRack | output | RACK_W (2) | Rack of the reported slot |
| slotId | output | 3 | Slot index, 0 = A |
| slotStart | output | ADDR_W (11) | First address of the slot |
| slotEnd | output | ADDR_W (11) | Last address of the slot |
| slotPoints | output | 6 | Capacity in points |
| rackErr | output | NUM_RACKS-1 (3) | Per-expansion-rack switch mismatch |
| limitErr | output | 1 | Last rack starts above the limit |

## Verification
The bench instantiates the block with NUM_RACKS = 3 and keeps the default 8-bit switch and the limit of 184. This gives 24 slots, so a full walk takes only a few dozen cycles. With such short walks the bench can run every uniform code, a set of arithmetic code mixtures and walks with a deliberately wrong switch on each expansion rack. It also builds rack layouts that place the last rack's start at exactly 184 and at 192, which exercises both sides of the limit check. A start pulse injected in the middle of a walk covers the requirement that such a pulse is ignored.

// File: rtl/rack_alloc_pkg.sv
package rack_alloc_pkg;

  typedef struct packed {
    logic clear;      // accept a new walk
    logic step;       // process the current slot
    logic firstSlot;  // current slot is slot A of its rack
    logic lastRack;   // current rack is the final rack
    logic finalSlot;  // current slot is the last one of the walk
  } walkStrobes_t;

  // first switch -> bit 1, second switch -> bit 0, 1 = open
  function automatic logic [5:0] capPoints(input logic [1:0] code);
    case (code)
      2'b00:   capPoints = 6'd0;
      2'b10:   capPoints = 6'd8;
      2'b01:   capPoints = 6'd16;
      default: capPoints = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/rack_alloc_ctrl.sv
module rack_alloc_ctrl
  import rack_alloc_pkg::*;
#(
  parameter int NUM_RACKS = 4,
  parameter int SLOTS     = 8,
  parameter int RACK_W    = 2,
  parameter int SLOT_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output walkStrobes_t      strb,
  output logic [RACK_W-1:0] rackIdx,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              busy,
  output logic              done
);

  localparam logic [RACK_W-1:0] LAST_RACK = RACK_W'(NUM_RACKS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  typedef enum logic {ST_IDLE, ST_WALK} walkState_t;
  walkState_t state;

  always_comb begin
    strb.clear     = (state == ST_IDLE) && start;
    strb.step      = (state == ST_WALK);
    strb.firstSlot = (slotIdx == '0);
    strb.lastRack  = (rackIdx == LAST_RACK);
    strb.finalSlot = strb.lastRack && (slotIdx == LAST_SLOT);
  end

  assign busy = (state == ST_WALK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rackIdx <= '0;
      slotIdx <= '0;
      done    <= 1'b0;
    end else if (strb.clear) begin
      state   <= ST_WALK;
      rackIdx <= '0;
      slotIdx <= '0;
      done    <= 1'b0;
    end else if (strb.step) begin
      if (strb.finalSlot) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end else if (slotIdx == LAST_SLOT) begin
        slotIdx <= '0;
        rackIdx <= rackIdx + 1'b1;
      end else begin
        slotIdx <= slotIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rack_alloc_dp.sv
module rack_alloc_dp
  import rack_alloc_pkg::*;
#(
  parameter int NUM_RACKS      = 4,
  parameter int SLOTS          = 8,
  parameter int RACK_W         = 2,
  parameter int SLOT_W         = 3,
  parameter int SW_W           = 8,
  parameter int SW_SHIFT       = 3,
  parameter int ADDR_W         = 11,
  parameter int LAST_START_MAX = 184
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  walkStrobes_t                    strb,
  input  logic [RACK_W-1:0]               rackIdx,
  input  logic [SLOT_W-1:0]               slotIdx,
  input  logic [NUM_RACKS*SLOTS*2-1:0]    capCodes,
  input  logic [(NUM_RACKS-1)*SW_W-1:0]   rackSw,
  output logic                            slotValid,
  output logic [RACK_W-1:0]               slotRack,
  output logic [SLOT_W-1:0]               slotId,
  output logic [ADDR_W-1:0]               slotStart,
  output logic [ADDR_W-1:0]               slotEnd,
  output logic [5:0]                      slotPoints,
  output logic [NUM_RACKS-2:0]            rackErr,
  output logic                            limitErr
);

  localparam int                TOTAL_SLOTS = NUM_RACKS * SLOTS;
  localparam logic [ADDR_W-1:0] LIMIT_A     = ADDR_W'(LAST_START_MAX);

  logic [ADDR_W-1:0] nextAddr;
  logic [1:0]        curCode;
  logic [5:0]        curPts;
  logic [ADDR_W-1:0] curPtsW;
  logic [SW_W-1:0]   curSw;
  logic [ADDR_W-1:0] swStart;
  int                flatIdx;

  // select the code of the current slot
  always_comb begin
    flatIdx = int'(rackIdx) * SLOTS + int'(slotIdx);
    curCode = 2'b00;
    for (int i = 0; i < TOTAL_SLOTS; i++) begin
      if (flatIdx == i) curCode = capCodes[2*i +: 2];
    end
    curPts  = capPoints(curCode);
    curPtsW = ADDR_W'(curPts);
  end

  // select the switch of the current expansion rack
  always_comb begin
    curSw = '0;
    for (int r = 1; r < NUM_RACKS; r++) begin
      if (rackIdx == RACK_W'(r)) curSw = rackSw[(r-1)*SW_W +: SW_W];
    end
    swStart = '0;
    swStart[SW_SHIFT +: SW_W] = curSw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextAddr   <= '0;
      slotValid  <= 1'b0;
      slotRack   <= '0;
      slotId     <= '0;
      slotStart  <= '0;
      slotEnd    <= '0;
      slotPoints <= '0;
      rackErr    <= '0;
      limitErr   <= 1'b0;
    end else if (strb.clear) begin
      nextAddr  <= '0;
      slotValid <= 1'b0;
      rackErr   <= '0;
      limitErr  <= 1'b0;
    end else if (strb.step) begin
      slotValid  <= 1'b1;
      slotRack   <= rackIdx;
      slotId     <= slotIdx;
      slotStart  <= nextAddr;
      slotEnd    <= (curPts == '0) ? nextAddr : nextAddr + curPtsW - 1'b1;
      slotPoints <= curPts;
      nextAddr   <= nextAddr + curPtsW;
      if (strb.firstSlot) begin
        for (int r = 1; r < NUM_RACKS; r++) begin
          if (rackIdx == RACK_W'(r)) rackErr[r-1] <= (swStart != nextAddr);
        end
        if (strb.lastRack) limitErr <= (nextAddr > LIMIT_A);
      end
    end else begin
      slotValid <= 1'b0;
    end
  end

endmodule

// File: rtl/rack_addr_alloc.sv
module rack_addr_alloc
  import rack_alloc_pkg::*;
#(
  parameter int NUM_RACKS      = 4,
  parameter int SW_W           = 8,
  parameter int LAST_START_MAX = 184,
  localparam int SLOTS         = 8,
  localparam int SW_SHIFT      = 3,
  localparam int SLOT_W        = $clog2(SLOTS),
  localparam int RACK_W        = (NUM_RACKS > 1) ? $clog2(NUM_RACKS) : 1,
  localparam int PTS_W         = $clog2(NUM_RACKS * SLOTS * 32 + 1),
  localparam int ADDR_W        = (PTS_W > SW_W + SW_SHIFT) ? PTS_W : SW_W + SW_SHIFT
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [NUM_RACKS*SLOTS*2-1:0]  capCodes,
  input  logic [(NUM_RACKS-1)*SW_W-1:0] rackSw,
  output logic                          busy,
  output logic                          done,
  output logic                          slotValid,
  output logic [RACK_W-1:0]             slotRack,
  output logic [SLOT_W-1:0]             slotId,
  output logic [ADDR_W-1:0]             slotStart,
  output logic [ADDR_W-1:0]             slotEnd,
  output logic [5:0]                    slotPoints,
  output logic [NUM_RACKS-2:0]          rackErr,
  output logic                          limitErr
);

  walkStrobes_t      strb;
  logic [RACK_W-1:0] rackIdx;
  logic [SLOT_W-1:0] slotIdx;

  rack_alloc_ctrl #(
    .NUM_RACKS(NUM_RACKS), .SLOTS(SLOTS), .RACK_W(RACK_W), .SLOT_W(SLOT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb),
    .rackIdx(rackIdx), .slotIdx(slotIdx), .busy(busy), .done(done)
  );

  rack_alloc_dp #(
    .NUM_RACKS(NUM_RACKS), .SLOTS(SLOTS), .RACK_W(RACK_W), .SLOT_W(SLOT_W),
    .SW_W(SW_W), .SW_SHIFT(SW_SHIFT), .ADDR_W(ADDR_W),
    .LAST_START_MAX(LAST_START_MAX)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rackIdx(rackIdx), .slotIdx(slotIdx),
    .capCodes(capCodes), .rackSw(rackSw), .slotValid(slotValid),
    .slotRack(slotRack), .slotId(slotId), .slotStart(slotStart),
    .slotEnd(slotEnd), .slotPoints(slotPoints), .rackErr(rackErr),
    .limitErr(limitErr)
  );

endmodule

// File: rtl/rack_addr_alloc_chk.sv
module rack_addr_alloc_chk #(
  parameter int ADDR_W = 11,
  parameter int RACK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              slotValid,
  input logic [RACK_W-1:0] slotRack,
  input logic [2:0]        slotId,
  input logic [ADDR_W-1:0] slotStart,
  input logic [ADDR_W-1:0] slotEnd,
  input logic [5:0]        slotPoints
);

  logic              prevValid;
  logic [RACK_W-1:0] prevRack;
  logic [2:0]        prevId;
  logic [ADDR_W-1:0] prevStart;
  logic [5:0]        prevPts;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevRack  <= '0;
      prevId    <= '0;
      prevStart <= '0;
      prevPts   <= '0;
    end else begin
      prevValid <= slotValid;
      prevRack  <= slotRack;
      prevId    <= slotId;
      prevStart <= slotStart;
      prevPts   <= slotPoints;
    end
  end

  AST_LEGAL_POINTS: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |-> (slotPoints == 6'd0 || slotPoints == 6'd8 ||
                   slotPoints == 6'd16 || slotPoints == 6'd32)); // R1

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && prevValid) |->
      ((slotRack == prevRack && slotId == prevId + 3'd1) ||
       (slotRack == prevRack + 1'b1 && slotId == 3'd0 && prevId == 3'd7))); // R2

  AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && slotRack == '0 && slotId == 3'd0) |-> slotStart == '0); // R3

  AST_CHAINED_START: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && prevValid) |-> slotStart == prevStart + ADDR_W'(prevPts)); // R3

  AST_END_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && slotPoints != 6'd0) |->
      slotEnd == slotStart + ADDR_W'(slotPoints) - 1'b1); // R4

  AST_EMPTY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && slotPoints == 6'd0) |-> slotEnd == slotStart); // R4

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy)); // R7

endmodule

bind rack_addr_alloc rack_addr_alloc_chk #(.ADDR_W(ADDR_W), .RACK_W(RACK_W)) i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .slotValid(slotValid),
  .slotRack(slotRack), .slotId(slotId), .slotStart(slotStart),
  .slotEnd(slotEnd), .slotPoints(slotPoints)
);

// File: tb/test_rack_addr_alloc.sv
module test_rack_addr_alloc;

  localparam int NR     = 3;
  localparam int NS     = NR * 8;
  localparam int ADDR_W = 11;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 start = 1'b0;
  logic [NR*16-1:0]     capCodes;
  logic [(NR-1)*8-1:0]  rackSw;
  logic                 busy, done, slotValid, limitErr;
  logic [1:0]           slotRack;
  logic [2:0]           slotId;
  logic [ADDR_W-1:0]    slotStart, slotEnd;
  logic [5:0]           slotPoints;
  logic [NR-2:0]        rackErr;

  logic [1:0] codes [NR][8];
  logic [7:0] sw [NR];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int r = 0; r < NR; r++)
      for (int s = 0; s < 8; s++) capCodes[(r*8+s)*2 +: 2] = codes[r][s];
    for (int r = 1; r < NR; r++) rackSw[(r-1)*8 +: 8] = sw[r];
  end

  rack_addr_alloc #(.NUM_RACKS(NR)) i_rack_addr_alloc (
    .clk(clk), .rstN(rstN), .start(start), .capCodes(capCodes), .rackSw(rackSw),
    .busy(busy), .done(done), .slotValid(slotValid), .slotRack(slotRack),
    .slotId(slotId), .slotStart(slotStart), .slotEnd(slotEnd),
    .slotPoints(slotPoints), .rackErr(rackErr), .limitErr(limitErr)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic int ptsOf(input logic [1:0] c);
    // R1: bit1 first switch, bit0 second, 1 = open
    case (c)
      2'b00: return 0;
      2'b10: return 8;
      2'b01: return 16;
      default: return 32;
    endcase
  endfunction

  // badRack: 0 = all switches correct, else that expansion rack is off by one step
  task automatic runWalk(input int badRack, input bit pokeStart);
    int expStart [NS];
    int expPts [NS];
    int chain [NR];
    int ptr;
    int expErr;
    ptr = 0;
    for (int r = 0; r < NR; r++) begin
      chain[r] = ptr;
      for (int s = 0; s < 8; s++) begin
        expStart[r*8+s] = ptr;
        expPts[r*8+s]   = ptsOf(codes[r][s]);
        ptr += expPts[r*8+s];
      end
    end
    sw[0] = 8'd0;
    for (int r = 1; r < NR; r++) sw[r] = 8'(chain[r] / 8 + ((r == badRack) ? 1 : 0));
    expErr = 0;
    for (int r = 1; r < NR; r++)
      if (int'(sw[r]) * 8 != chain[r]) expErr |= (1 << (r - 1));

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chkEq("R7 busy after start", int'(busy), 1);
    chkEq("R7 errors cleared by start", int'(rackErr), 0);
    chkEq("R2 no slot in start cycle", int'(slotValid), 0);
    for (int j = 0; j < NS; j++) begin
      @(negedge clk);
      start = 1'b0;
      chkEq("R2 slotValid", int'(slotValid), 1);
      chkEq("R2 slotRack", int'(slotRack), j / 8);
      chkEq("R2 slotId", int'(slotId), j % 8);
      chkEq("R1 slotPoints", int'(slotPoints), expPts[j]);
      chkEq("R3 slotStart", int'(slotStart), expStart[j]);
      chkEq("R4 slotEnd", int'(slotEnd),
            (expPts[j] == 0) ? expStart[j] : expStart[j] + expPts[j] - 1);
      chkEq("R7 done timing", int'(done), (j == NS - 1) ? 1 : 0);
      chkEq("R7 busy timing", int'(busy), (j == NS - 1) ? 0 : 1);
      if (pokeStart && j == 4) start = 1'b1; // R8: pulse while busy
    end
    @(negedge clk);
    chkEq("R2 slotValid after walk", int'(slotValid), 0);
    chkEq("R7 done holds", int'(done), 1);
    chkEq("R5 rackErr", int'(rackErr), expErr);
    chkEq("R6 limitErr", int'(limitErr), (chain[NR-1] > 184) ? 1 : 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic fillAll(input logic [1:0] c);
    for (int r = 0; r < NR; r++)
      for (int s = 0; s < 8; s++) codes[r][s] = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    fillAll(2'b11);
    for (int r = 0; r < NR; r++) sw[r] = 8'd0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chkEq("R9 busy", int'(busy), 0);
    chkEq("R9 done", int'(done), 0);
    chkEq("R9 slotValid", int'(slotValid), 0);
    chkEq("R9 rackErr", int'(rackErr), 0);
    chkEq("R9 limitErr", int'(limitErr), 0);
    rstN = 1'b1;
    @(negedge clk);

    // uniform codes: factory default 32 first, then the other three
    runWalk(0, 1'b0);
    fillAll(2'b00); runWalk(0, 1'b0);
    fillAll(2'b10); runWalk(1, 1'b0);
    fillAll(2'b01); runWalk(2, 1'b0);

    // R6 boundary: last rack starts exactly at 184
    fillAll(2'b00);
    for (int s = 0; s < 5; s++) codes[0][s] = 2'b11;
    codes[0][5] = 2'b01;
    codes[0][6] = 2'b10;
    runWalk(0, 1'b0);

    // R6 boundary: last rack starts at 192
    fillAll(2'b00);
    for (int s = 0; s < 6; s++) codes[0][s] = 2'b11;
    runWalk(0, 1'b0);

    // mixed-capacity sweep, with mismatches and a start pulse mid-walk (R8)
    for (int k = 0; k < 12; k++) begin
      for (int r = 0; r < NR; r++)
        for (int s = 0; s < 8; s++)
          codes[r][s] = 2'((r*5 + s*3 + k*7 + ((s*k) >> 1)) % 4);
      runWalk(k % NR, k == 3 || k == 8);
    end

    summary();
  end

endmodule